// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides how a small 8-bit microcontroller core is clocked and when it sleeps. A mode-select bit chooses the system clock source: with the bit clear the core runs from the high-frequency oscillator (Normal mode), and with it set the core runs from the low-frequency crystal (Slow mode). A move from one source to the other goes through a two-phase handover. First the core clock is gated off. Then the multiplexer select changes. Then the clock is ungated. Because of this, no shortened pulse from either source reaches the core.

A halt strobe from the instruction decoder is accepted in either mode. It stalls the core with its state held and stops the high-frequency oscillator. If the crystal is configured, it keeps running through Sleep. A halt also clears the watchdog. The watchdog keeps counting only when its clock comes from the internal low-frequency RC or from the crystal. Halt sets the power-down flag and clears the time-out flag. An interrupt wake request or a watchdog time-out restarts the oscillator. The core is released once a fixed number of ready cycles of the selected source have been counted.

Top module: `power_mode_ctl`

## Requirements
- R1: After reset `clk_sel_slow` is 0 (high-frequency source) and the core is not stalled. `clk_sel_slow` follows `slow_sel` (1 = low-frequency crystal) once a handover completes.
- R2: A change of `slow_sel` while running raises `core_stall` for 2*HAND_CYC cycles. `clk_sel_slow` changes only after the first HAND_CYC stalled cycles, never while `core_stall` is low.
- R3: A `halt_req` sampled while running, in either mode, gives `core_stall`=1 and `hosc_en`=0 on the next cycle.
- R4: `lxt_en` equals `lxt_cfg` in every state, including Sleep.
- R5: `wdt_clr` is a one-cycle pulse on Sleep entry. In Sleep `wdt_run` is 0 only when `wdt_src` selects the system clock (00 or 11); 01 is the internal low-frequency RC and 10 is the crystal. `lirc_en` is 1 exactly when `wdt_src`=01.
- R6: An accepted halt sets `pdf` and clears `to_flag`. `pdf` stays set until a `pdf_clr` pulse or reset, and reset clears both flags.
- R7: In Sleep, `wake_req` re-enables `hosc_en` on the next cycle. `core_stall` falls after WARM_CYC cycles in which the ready input of the selected source (`hosc_rdy` when `clk_sel_slow`=0, else `lxt_rdy`) is high. Cycles with ready low are not counted.
- R8: `wdt_timeout` sets `to_flag` and, in Sleep, wakes the device exactly like `wake_req`.
- R9: `halt_req` has no effect while the core is stalled by a handover or warm-up. When a halt and a mode change arrive together, the halt wins and the handover is deferred until after wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low power-on reset |
| slow_sel | input | 1 | Mode select: 0 Normal, 1 Slow |
| halt_req | input | 1 | Halt strobe from the instruction decoder |
| wake_req | input | 1 | Interrupt wake request |
| wdt_timeout | input | 1 | Watchdog time-out event |
| pdf_clr | input | 1 | Software clear of the power-down flag |
| hosc_rdy | input | 1 | High-frequency oscillator running and stable |
| lxt_rdy | input | 1 | Low-frequency crystal running and stable |
| lxt_cfg | input | 1 | Crystal configured for use |
| wdt_src | input | 2 | Watchdog clock: 00/11 system, 01 internal RC, 10 crystal |
| hosc_en | output | 1 | High-frequency oscillator enable |
| lxt_en | output | 1 | Crystal oscillator enable |
| lirc_en | output | 1 | Internal low-frequency RC enable |
| clk_sel_slow | output | 1 | System clock multiplexer select |
| core_stall | output | 1 | Core clock gated, state held |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| wdt_run | output | 1 | Watchdog counting enable |
| pdf | output | 1 | Power-down flag |
| to_flag | output | 1 | Watchdog time-out flag |

## Verification
The Normal-to-Slow and Slow-to-Normal switches are both timed. This confirms that the select moves in the middle of the stall and not at either end. Sleep is entered from each mode with each watchdog clock source, which separates the oscillator-stop rule from the watchdog-stop rule. One warm-up starts with the ready input held low, which distinguishes counting ready cycles from counting clock cycles. Wakes come from both an interrupt and a time-out, and a halt is given during a stall and together with a mode change. These cases expose whether the halt is correctly gated and given priority.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_HOFF  = 3'd1,
        ST_HON   = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WARM  = 3'd4
    } pmc_state_e;

    typedef enum logic [1:0] {
        WSRC_SYS  = 2'b00,
        WSRC_LIRC = 2'b01,
        WSRC_LXT  = 2'b10,
        WSRC_SYS2 = 2'b11
    } wdt_src_e;

endpackage

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int WARM_CYC = 16,
    parameter int HAND_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_sel,
    input  logic halt_req,
    input  logic wake_req,
    input  logic wdt_timeout,
    input  logic hosc_rdy,
    input  logic lxt_rdy,
    output logic halt_take,
    output logic stall,
    output logic hosc_on,
    output logic sel_slow
);
    localparam int MAXC = (WARM_CYC > HAND_CYC) ? WARM_CYC : HAND_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYC - 1);
    localparam logic [CNT_W-1:0] HAND_LAST = CNT_W'(HAND_CYC - 1);

    typedef struct packed {
        pmc_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             sel;
    } fsm_t;

    fsm_t q, d;
    logic src_rdy;

    always_comb begin
        d         = q;
        halt_take = 1'b0;
        src_rdy   = q.sel ? lxt_rdy : hosc_rdy;
        case (q.state)
            ST_RUN: begin
                if (halt_req) begin
                    halt_take = 1'b1;
                    d.state   = ST_SLEEP;
                end else if (slow_sel != q.sel) begin
                    d.state = ST_HOFF;
                    d.cnt   = '0;
                end
            end
            ST_HOFF: begin
                if (q.cnt == HAND_LAST) begin
                    d.cnt   = '0;
                    d.sel   = ~q.sel;
                    d.state = ST_HON;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HON: begin
                if (q.cnt == HAND_LAST) begin
                    d.state = ST_RUN;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SLEEP: begin
                if (wake_req || wdt_timeout) begin
                    d.state = ST_WARM;
                    d.cnt   = '0;
                end
            end
            ST_WARM: begin
                if (src_rdy) begin
                    if (q.cnt == WARM_LAST) begin
                        d.state = ST_RUN;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_RUN, cnt: '0, sel: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign stall    = (q.state != ST_RUN);
    assign hosc_on  = (q.state != ST_SLEEP);
    assign sel_slow = q.sel;

endmodule

// File: rtl/pmc_flags.sv
module pmc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_take,
    input  logic wdt_timeout,
    input  logic pdf_clr,
    output logic pdf,
    output logic to_flag,
    output logic wdt_clr
);
    typedef struct packed {
        logic pdf;
        logic to;
        logic clr;
    } flg_t;

    flg_t q, d;

    always_comb begin
        d     = q;
        d.clr = halt_take;
        if (halt_take) begin
            d.pdf = 1'b1;
        end else if (pdf_clr) begin
            d.pdf = 1'b0;
        end
        if (wdt_timeout) begin
            d.to = 1'b1;
        end else if (halt_take) begin
            d.to = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pdf     = q.pdf;
    assign to_flag = q.to;
    assign wdt_clr = q.clr;

endmodule

// File: rtl/pmc_wdt_gate.sv
module pmc_wdt_gate
    import pmc_pkg::*;
(
    input  logic       asleep,
    input  logic [1:0] wdt_src,
    output logic       wdt_run,
    output logic       lirc_en
);
    wdt_src_e src;

    always_comb begin
        src     = wdt_src_e'(wdt_src);
        lirc_en = (src == WSRC_LIRC);
        wdt_run = !(asleep && (src == WSRC_SYS || src == WSRC_SYS2));
    end

endmodule

// File: rtl/power_mode_ctl.sv
module power_mode_ctl #(
    parameter int WARM_CYC = 16,
    parameter int HAND_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_sel,
    input  logic       halt_req,
    input  logic       wake_req,
    input  logic       wdt_timeout,
    input  logic       pdf_clr,
    input  logic       hosc_rdy,
    input  logic       lxt_rdy,
    input  logic       lxt_cfg,
    input  logic [1:0] wdt_src,
    output logic       hosc_en,
    output logic       lxt_en,
    output logic       lirc_en,
    output logic       clk_sel_slow,
    output logic       core_stall,
    output logic       wdt_clr,
    output logic       wdt_run,
    output logic       pdf,
    output logic       to_flag
);
    logic halt_take;
    logic hosc_on;

    pmc_mode_fsm #(.WARM_CYC(WARM_CYC), .HAND_CYC(HAND_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_sel    (slow_sel),
        .halt_req    (halt_req),
        .wake_req    (wake_req),
        .wdt_timeout (wdt_timeout),
        .hosc_rdy    (hosc_rdy),
        .lxt_rdy     (lxt_rdy),
        .halt_take   (halt_take),
        .stall       (core_stall),
        .hosc_on     (hosc_on),
        .sel_slow    (clk_sel_slow)
    );

    pmc_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_take   (halt_take),
        .wdt_timeout (wdt_timeout),
        .pdf_clr     (pdf_clr),
        .pdf         (pdf),
        .to_flag     (to_flag),
        .wdt_clr     (wdt_clr)
    );

    pmc_wdt_gate u_wdt (
        .asleep  (!hosc_on),
        .wdt_src (wdt_src),
        .wdt_run (wdt_run),
        .lirc_en (lirc_en)
    );

    assign hosc_en = hosc_on;
    assign lxt_en  = lxt_cfg;

endmodule

// File: rtl/power_mode_ctl_chk.sv
module power_mode_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req,
    input logic [1:0] wdt_src,
    input logic       hosc_en,
    input logic       clk_sel_slow,
    input logic       core_stall,
    input logic       wdt_clr,
    input logic       wdt_run,
    input logic       pdf,
    input logic       to_flag,
    input logic       wdt_timeout
);
    p_sel_in_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel_slow) |-> (core_stall && $past(core_stall)));

    p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |-> (core_stall && !hosc_en));

    p_osc_off_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hosc_en |-> core_stall);

    p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);

    p_wdt_sys_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hosc_en && (wdt_src == 2'b00 || wdt_src == 2'b11)) |-> !wdt_run);

    p_halt_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !core_stall && !wdt_timeout) |=> (pdf && !to_flag));

    p_timeout_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> to_flag);

endmodule

bind power_mode_ctl power_mode_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req),
    .wdt_src      (wdt_src),
    .hosc_en      (hosc_en),
    .clk_sel_slow (clk_sel_slow),
    .core_stall   (core_stall),
    .wdt_clr      (wdt_clr),
    .wdt_run      (wdt_run),
    .pdf          (pdf),
    .to_flag      (to_flag),
    .wdt_timeout  (wdt_timeout)
);

// File: tb/power_mode_ctl_bench.sv
module power_mode_ctl_bench;
    localparam int WARM = 16;
    localparam int HAND = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_sel = 1'b0, halt_req = 1'b0, wake_req = 1'b0, wdt_timeout = 1'b0;
    logic pdf_clr = 1'b0, hosc_rdy = 1'b0, lxt_rdy = 1'b0, lxt_cfg = 1'b0;
    logic [1:0] wdt_src = 2'b00;
    logic hosc_en, lxt_en, lirc_en, clk_sel_slow, core_stall, wdt_clr, wdt_run, pdf, to_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    power_mode_ctl #(.WARM_CYC(WARM), .HAND_CYC(HAND)) u_power_mode_ctl (
        .clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .halt_req(halt_req),
        .wake_req(wake_req), .wdt_timeout(wdt_timeout), .pdf_clr(pdf_clr),
        .hosc_rdy(hosc_rdy), .lxt_rdy(lxt_rdy), .lxt_cfg(lxt_cfg), .wdt_src(wdt_src),
        .hosc_en(hosc_en), .lxt_en(lxt_en), .lirc_en(lirc_en), .clk_sel_slow(clk_sel_slow),
        .core_stall(core_stall), .wdt_clr(wdt_clr), .wdt_run(wdt_run), .pdf(pdf),
        .to_flag(to_flag)
    );

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        chk("R1", "stall after reset", core_stall, 1'b0);
        chk("R1", "sel after reset", clk_sel_slow, 1'b0);
        chk("R6", "pdf after reset", pdf, 1'b0);
        chk("R6", "to after reset", to_flag, 1'b0);
        chk("R3", "hosc_en after reset", hosc_en, 1'b1);
        chk("R5", "wdt_clr after reset", wdt_clr, 1'b0);
    endtask

    task automatic t_switch(logic tgt);
        slow_sel = tgt;
        tick(HAND);
        chk("R2", "sel held in first phase", clk_sel_slow, ~tgt);
        chk("R2", "stall first phase", core_stall, 1'b1);
        tick(1);
        chk("R1", "sel after flip", clk_sel_slow, tgt);
        tick(HAND - 1);
        chk("R2", "stall second phase", core_stall, 1'b1);
        tick(1);
        chk("R2", "stall released", core_stall, 1'b0);
    endtask

    task automatic t_sleep_normal();
        wdt_src = 2'b00; lxt_cfg = 1'b0; hosc_rdy = 1'b0;
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        chk("R3", "stall in sleep", core_stall, 1'b1);
        chk("R3", "hosc off", hosc_en, 1'b0);
        chk("R6", "pdf set", pdf, 1'b1);
        chk("R6", "to clear", to_flag, 1'b0);
        chk("R5", "wdt_clr pulse", wdt_clr, 1'b1);
        chk("R5", "wdt stopped sys src", wdt_run, 1'b0);
        chk("R4", "lxt off unconfigured", lxt_en, 1'b0);
        wdt_src = 2'b11; #1;
        chk("R5", "wdt stopped src 11", wdt_run, 1'b0);
        wdt_src = 2'b00;
        tick(1);
        chk("R5", "wdt_clr one cycle", wdt_clr, 1'b0);
        tick(3);
        chk("R3", "still asleep", core_stall, 1'b1);
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
        chk("R7", "hosc re-enabled", hosc_en, 1'b1);
        tick(3);
        chk("R7", "no count without ready", core_stall, 1'b1);
        hosc_rdy = 1'b1;
        tick(WARM - 1);
        chk("R7", "stall one before warm end", core_stall, 1'b1);
        tick(1);
        chk("R7", "released after warm", core_stall, 1'b0);
        chk("R6", "pdf kept after wake", pdf, 1'b1);
        pdf_clr = 1'b1; tick(1); pdf_clr = 1'b0;
        chk("R6", "pdf cleared by sw", pdf, 1'b0);
    endtask

    task automatic t_sleep_slow();
        lxt_cfg = 1'b1; lxt_rdy = 1'b1; wdt_src = 2'b10;
        t_switch(1'b1);
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        chk("R3", "halt in slow mode", core_stall, 1'b1);
        chk("R3", "hosc off from slow", hosc_en, 1'b0);
        chk("R4", "crystal kept in sleep", lxt_en, 1'b1);
        chk("R5", "wdt runs on crystal", wdt_run, 1'b1);
        chk("R5", "lirc off for crystal src", lirc_en, 1'b0);
        wdt_timeout = 1'b1; tick(1); wdt_timeout = 1'b0;
        chk("R8", "to set by timeout", to_flag, 1'b1);
        chk("R8", "timeout wakes", hosc_en, 1'b1);
        tick(WARM - 1);
        chk("R7", "slow warm pending", core_stall, 1'b1);
        tick(1);
        chk("R7", "slow warm done", core_stall, 1'b0);
        chk("R1", "slow sel kept", clk_sel_slow, 1'b1);
    endtask

    task automatic t_lirc();
        wdt_src = 2'b01; #1;
        chk("R5", "lirc enabled", lirc_en, 1'b1);
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        chk("R6", "halt clears to", to_flag, 1'b0);
        chk("R5", "wdt runs on lirc", wdt_run, 1'b1);
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
        tick(WARM);
        chk("R7", "lirc wake done", core_stall, 1'b0);
    endtask

    task automatic t_priority();
        pdf_clr = 1'b1; tick(1); pdf_clr = 1'b0;
        slow_sel = 1'b0; halt_req = 1'b1; tick(1); halt_req = 1'b0;
        chk("R9", "halt beats mode change", hosc_en, 1'b0);
        chk("R9", "sel unchanged on halt", clk_sel_slow, 1'b1);
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
        tick(WARM);
        chk("R9", "run after warm", core_stall, 1'b0);
        chk("R9", "sel still slow", clk_sel_slow, 1'b1);
        tick(HAND + 1);
        chk("R9", "deferred switch applied", clk_sel_slow, 1'b0);
        tick(HAND);
        chk("R2", "deferred switch done", core_stall, 1'b0);
        pdf_clr = 1'b1; tick(1); pdf_clr = 1'b0;
        slow_sel = 1'b1; tick(1);
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        chk("R9", "halt in stall no pdf", pdf, 1'b0);
        chk("R9", "halt in stall hosc on", hosc_en, 1'b1);
        tick(2 * HAND - 1);
        chk("R9", "handover unaffected", core_stall, 1'b0);
        chk("R9", "sel reached slow", clk_sel_slow, 1'b1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_switch(1'b1);
        t_switch(1'b0);
        t_sleep_normal();
        t_sleep_slow();
        t_lirc();
        t_priority();
        finish_run();
    end

endmodule